// File: doc/BRIEF.md
# Traceback Survivor Memory and Decoder

This block sits behind the add-compare-select stage of a hard-decision decoder for a four-state, rate 1/n convolutional code. Each trellis stage delivers one decision bit per state. The bit tells which of the two branches entering that state survived. The block keeps these decisions in a store of one column per stage and writes each new column in place, so earlier columns are never shifted. Once a whole frame of eight stages has been stored and the frame end is signalled, the block walks the stored decisions backward. The walk starts in state 0, because a two-stage zero tail drives the encoder back to that state.

The walk covers one stage per clock. It turns the parity of each state it visits into a decoded bit. When it reaches the first stage, the block sends out the information bits in forward time order, one per clock. It drops the two tail bits, then raises a one-cycle done pulse. New decisions are refused from the moment the frame end is accepted until the done pulse has been given.

Top module: `tbk_decoder`

## Requirements
- R1: While reset is high, and in the first cycle after it, `in_ready` is 1 and `bit_valid` and `done` are 0.
- R2: Bit i of `dec_vec` is the decision for state i. A 1 means the upper branch survived and a 0 means the lower branch survived. From state s with decision d, the walk moves to the predecessor state ((s*2) mod 4) + (1 - d).
- R3: A frame holds exactly 8 decision vectors, stored in arrival order. A vector is taken only in a cycle where `dec_valid` and `in_ready` are both 1. `in_ready` falls after the 8th vector, and vectors offered while it is low do not change the decoded result.
- R4: `frame_end` is accepted only in a cycle where the stored count, after counting that same cycle's vector, equals 8. This includes the cycle of the 8th vector. In any other cycle `frame_end` has no effect.
- R5: The walk starts in state 0 at the last stage and covers one stage per clock, 8 clocks in all. During those clocks `bit_valid` and `done` stay 0.
- R6: The state reached at stage k (k = 1..8) gives decoded bit k. That bit is 0 when the state is even and 1 when it is odd.
- R7: `bit_valid` is high for 6 consecutive cycles, beginning in the 9th cycle after the edge that accepted `frame_end`. In those cycles `bit_out` carries decoded bits 1 to 6 in that order. Bits 7 and 8, the tail, are never output.
- R8: `done` is high for exactly one cycle, the cycle right after the last valid bit. In the cycle after that, `in_ready` is 1 and a new frame may begin.
- R9: `in_ready` is 0 from the edge that accepts `frame_end` until `done` has been given.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_vec | input | 4 | Survivor decisions of one stage, one bit per state |
| dec_valid | input | 1 | `dec_vec` holds a stage |
| frame_end | input | 1 | Last stage of the frame has arrived |
| in_ready | output | 1 | A decision vector would be stored this cycle |
| bit_out | output | 1 | Decoded information bit |
| bit_valid | output | 1 | `bit_out` is valid |
| done | output | 1 | One-cycle pulse after the last decoded bit |

## Verification
The write of the eighth column and the acceptance of the frame end can fall in the same cycle. The bench provokes this by raising `frame_end` together with the eighth vector, and judges it by requiring that the walk starts at the next edge using that column. The same moment is also reached with `frame_end` one or more cycles later. A frame end given too early, and vectors offered while the block is busy, are driven on purpose. The behavioural model predicts every cycle of `in_ready`, `bit_valid`, `bit_out` and `done`, and the bench compares the design against it on each clock.

// File: rtl/tbk_pkg.sv
package tbk_pkg;

    localparam int DEF_STATES = 4;
    localparam int DEF_STAGES = 8;
    localparam int DEF_TAIL   = 2;

    typedef enum logic [1:0] {
        PH_COLLECT,
        PH_TRACE,
        PH_EMIT,
        PH_DONE
    } phase_e;

    // Control strobes handed from the frame controller to the datapath
    typedef struct packed {
        logic wr_en;
        logic walk_start;
        logic walk_step;
    } ctl_t;

endpackage

// File: rtl/tbk_surv_mem.sv
module tbk_surv_mem #(
    parameter int NS    = tbk_pkg::DEF_STATES,
    parameter int DEPTH = tbk_pkg::DEF_STAGES,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = $clog2(NS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          we,
    input  logic [AW-1:0] wcol,
    input  logic [NS-1:0] wvec,
    input  logic [AW-1:0] rcol,
    input  logic [SW-1:0] rstate,
    output logic          rbit
);

    logic [NS-1:0] col_q [DEPTH];

    // Selective update: only the addressed column is written
    always_ff @(posedge clk) begin
        for (int c = 0; c < DEPTH; c++) begin
            if (rst) begin
                col_q[c] <= '0;
            end else if (we && (wcol == AW'(c))) begin
                col_q[c] <= wvec;
            end
        end
    end

    assign rbit = col_q[rcol][rstate];

endmodule

// File: rtl/tbk_walker.sv
module tbk_walker #(
    parameter int NS    = tbk_pkg::DEF_STATES,
    parameter int DEPTH = tbk_pkg::DEF_STAGES,
    localparam int AW   = $clog2(DEPTH),
    localparam int SW   = $clog2(NS)
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             start,
    input  logic             step,
    input  logic [AW-1:0]    col,
    input  logic             rbit,
    output logic [SW-1:0]    cur_state,
    output logic [DEPTH-1:0] bits
);

    logic [SW-1:0] pred;

    // Predecessor: shift the state up, fill the low bit with the inverted decision
    assign pred = {cur_state[SW-2:0], ~rbit};

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_state <= '0;
            bits      <= '0;
        end else if (start) begin
            cur_state <= '0;
        end else if (step) begin
            bits[col] <= cur_state[0];
            cur_state <= pred;
        end
    end

    // R5
    start_zero_chk: assert property (@(posedge clk) disable iff (rst)
        start |=> (cur_state == '0));

    // R6
    parity_bit_chk: assert property (@(posedge clk) disable iff (rst)
        step |=> (bits[$past(col)] == $past(cur_state[0])));

endmodule

// File: rtl/tbk_frame_ctrl.sv
module tbk_frame_ctrl
    import tbk_pkg::*;
#(
    parameter int DEPTH = tbk_pkg::DEF_STAGES,
    parameter int INFO  = tbk_pkg::DEF_STAGES - tbk_pkg::DEF_TAIL,
    localparam int AW   = $clog2(DEPTH),
    localparam int CW   = AW + 1
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          dec_valid,
    input  logic          frame_end,
    output logic          in_ready,
    output ctl_t          ctl,
    output logic [AW-1:0] wcol,
    output logic [AW-1:0] rcol,
    output logic [AW-1:0] emit_idx,
    output logic          bit_valid,
    output logic          done
);

    phase_e        phase;
    logic [CW-1:0] cnt;
    logic [CW-1:0] cnt_nx;
    logic [AW-1:0] ptr;
    logic          accept;

    always_comb begin
        in_ready        = (phase == PH_COLLECT) && (cnt < CW'(DEPTH));
        ctl.wr_en       = dec_valid && in_ready;
        cnt_nx          = cnt + CW'(ctl.wr_en);
        accept          = (phase == PH_COLLECT) && frame_end && (cnt_nx == CW'(DEPTH));
        ctl.walk_start  = accept;
        ctl.walk_step   = (phase == PH_TRACE);
        bit_valid       = (phase == PH_EMIT);
        done            = (phase == PH_DONE);
        wcol            = cnt[AW-1:0];
        rcol            = ptr;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            phase    <= PH_COLLECT;
            cnt      <= '0;
            ptr      <= '0;
            emit_idx <= '0;
        end else begin
            case (phase)
                PH_COLLECT: begin
                    cnt <= cnt_nx;
                    if (accept) begin
                        phase <= PH_TRACE;
                        ptr   <= AW'(DEPTH - 1);
                    end
                end
                PH_TRACE: begin
                    if (ptr == '0) begin
                        phase    <= PH_EMIT;
                        emit_idx <= '0;
                    end else begin
                        ptr <= ptr - 1'b1;
                    end
                end
                PH_EMIT: begin
                    if (emit_idx == AW'(INFO - 1)) begin
                        phase <= PH_DONE;
                    end else begin
                        emit_idx <= emit_idx + 1'b1;
                    end
                end
                default: begin
                    phase <= PH_COLLECT;
                    cnt   <= '0;
                end
            endcase
        end
    end

    // R3
    cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
        cnt <= CW'(DEPTH));

    // R8
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done);

    // R8
    ready_after_done_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> in_ready);

    // R9
    busy_ready_chk: assert property (@(posedge clk) disable iff (rst)
        ctl.walk_start |=> !in_ready);

    // R7
    emit_after_walk_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(bit_valid) |-> $past(ctl.walk_step));

endmodule

// File: rtl/tbk_decoder.sv
module tbk_decoder
    import tbk_pkg::*;
#(
    parameter int NUM_STATES   = tbk_pkg::DEF_STATES,
    parameter int FRAME_STAGES = tbk_pkg::DEF_STAGES,
    parameter int TAIL_STAGES  = tbk_pkg::DEF_TAIL,
    localparam int INFO_BITS   = FRAME_STAGES - TAIL_STAGES,
    localparam int AW          = $clog2(FRAME_STAGES),
    localparam int SW          = $clog2(NUM_STATES)
) (
    input  logic                  clk,
    input  logic                  rst,
    input  logic [NUM_STATES-1:0] dec_vec,
    input  logic                  dec_valid,
    input  logic                  frame_end,
    output logic                  in_ready,
    output logic                  bit_out,
    output logic                  bit_valid,
    output logic                  done
);

    ctl_t                    ctl;
    logic [AW-1:0]           wcol;
    logic [AW-1:0]           rcol;
    logic [AW-1:0]           emit_idx;
    logic [SW-1:0]           cur_state;
    logic                    rbit;
    logic [FRAME_STAGES-1:0] bits;

    tbk_frame_ctrl #(
        .DEPTH(FRAME_STAGES),
        .INFO (INFO_BITS)
    ) u_ctrl (
        .clk      (clk),
        .rst      (rst),
        .dec_valid(dec_valid),
        .frame_end(frame_end),
        .in_ready (in_ready),
        .ctl      (ctl),
        .wcol     (wcol),
        .rcol     (rcol),
        .emit_idx (emit_idx),
        .bit_valid(bit_valid),
        .done     (done)
    );

    tbk_surv_mem #(
        .NS   (NUM_STATES),
        .DEPTH(FRAME_STAGES)
    ) u_mem (
        .clk   (clk),
        .rst   (rst),
        .we    (ctl.wr_en),
        .wcol  (wcol),
        .wvec  (dec_vec),
        .rcol  (rcol),
        .rstate(cur_state),
        .rbit  (rbit)
    );

    tbk_walker #(
        .NS   (NUM_STATES),
        .DEPTH(FRAME_STAGES)
    ) u_walk (
        .clk      (clk),
        .rst      (rst),
        .start    (ctl.walk_start),
        .step     (ctl.walk_step),
        .col      (rcol),
        .rbit     (rbit),
        .cur_state(cur_state),
        .bits     (bits)
    );

    assign bit_out = bit_valid ? bits[emit_idx] : 1'b0;

    // R7
    quiet_bit_chk: assert property (@(posedge clk) disable iff (rst)
        !bit_valid |-> !bit_out);

endmodule

// File: tb/sim_tbk_decoder.sv
module sim_tbk_decoder;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] dvec = '0;
    logic       dval = 1'b0;
    logic       dfe  = 1'b0;
    logic       in_ready, bit_out, bit_valid, done;

    always #5 clk = ~clk;

    tbk_decoder u0 (
        .clk      (clk),
        .rst      (rst),
        .dec_vec  (dvec),
        .dec_valid(dval),
        .frame_end(dfe),
        .in_ready (in_ready),
        .bit_out  (bit_out),
        .bit_valid(bit_valid),
        .done     (done)
    );

    int n_chk = 0;
    int n_bad = 0;
    bit reported = 0;

    // Behavioural reference model
    logic [3:0] mq [8];
    logic       eb [8];
    int m_stage = 0;   // 0 collect, 1 walk, 2 emit, 3 done
    int m_cnt = 0, m_timer = 0, m_idx = 0, m_frames = 0;
    bit started = 0;

    always @(posedge clk) begin
        started <= 1'b1;
        if (rst) begin
            m_stage = 0; m_cnt = 0; m_timer = 0; m_idx = 0;
        end else begin
            case (m_stage)
                0: begin
                    int nc;
                    nc = m_cnt;
                    if (dval && m_cnt < 8) begin
                        mq[m_cnt] = dvec;
                        nc = m_cnt + 1;
                    end
                    m_cnt = nc;
                    if (dfe && nc == 8) begin
                        int s;
                        s = 0;
                        for (int k = 7; k >= 0; k--) begin
                            eb[k] = s[0];
                            s = ((s * 2) % 4) + (mq[k][s] ? 0 : 1);
                        end
                        m_stage = 1; m_timer = 8;
                    end
                end
                1: begin
                    m_timer--;
                    if (m_timer == 0) begin m_stage = 2; m_idx = 0; end
                end
                2: begin
                    m_idx++;
                    if (m_idx == 6) m_stage = 3;
                end
                default: begin
                    m_stage = 0; m_cnt = 0; m_frames++;
                end
            endcase
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    // Compare outputs away from the active edge
    always @(negedge clk) begin
        if (started) begin
            bit er, ev, ed;
            er = (m_stage == 0) && (m_cnt < 8);
            ev = (m_stage == 2);
            ed = (m_stage == 3);
            if (rst) begin
                chk(in_ready == 1'b1 && bit_valid == 1'b0 && done == 1'b0,
                    "R1 reset outputs", {in_ready, bit_valid, done}, 3'b100);
            end else begin
                chk(in_ready == er, "R3 R9 in_ready", in_ready, er);
                chk(bit_valid == ev, "R5 R7 bit_valid", bit_valid, ev);
                chk(done == ed, "R8 done", done, ed);
                if (ev && bit_valid)
                    chk(bit_out == eb[m_idx], "R6 R2 bit_out", bit_out, eb[m_idx]);
            end
        end
    end

    task automatic report();
        if (!reported) begin
            reported = 1;
            $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
        end
    endtask

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            report();
            $finish;
        end
    end

    task automatic drive(input logic [3:0] v, input bit val, input bit fe);
        @(negedge clk);
        dvec = v; dval = val; dfe = fe;
    endtask

    task automatic wait_frame(input int target, input bit busy_spam);
        while (m_frames < target) drive(4'hA, busy_spam, 1'b0);
        drive(4'h0, 1'b0, 1'b0);
    endtask

    function automatic logic [3:0] pat(input int f, input int i);
        int x;
        x = (f * 37 + i * 11 + 5) ^ (f << i);
        return x[3:0];
    endfunction

    initial begin
        int tgt;
        tgt = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R4: all upper decisions, frame_end with the 8th vector -> all zeros
        for (int i = 0; i < 8; i++) drive(4'hF, 1'b1, i == 7);
        tgt++; wait_frame(tgt, 1'b0);

        // R2: all lower decisions -> decoded ones, frame_end one cycle late
        for (int i = 0; i < 8; i++) drive(4'h0, 1'b1, 1'b0);
        drive(4'h0, 1'b0, 1'b1);
        tgt++; wait_frame(tgt, 1'b0);

        // R4: early frame_end ignored; R3: gaps and extra vectors ignored
        for (int i = 0; i < 8; i++) begin
            drive(pat(2, i), 1'b1, i == 4);
            drive(4'h0, 1'b0, 1'b0);
        end
        drive(4'h5, 1'b1, 1'b0);
        drive(4'h9, 1'b1, 1'b0);
        drive(4'h0, 1'b0, 1'b1);
        tgt++; wait_frame(tgt, 1'b0);

        // R9: vectors offered during walk and emit must not be stored
        for (int i = 0; i < 8; i++) drive(pat(3, i), 1'b1, i == 7);
        tgt++; wait_frame(tgt, 1'b1);

        // R6 R7: varied frames back to back
        for (int f = 4; f < 12; f++) begin
            for (int i = 0; i < 8; i++) drive(pat(f, i), 1'b1, (i == 7) && f[0]);
            if (!f[0]) drive(4'h0, 1'b0, 1'b1);
            tgt++; wait_frame(tgt, f[1]);
        end

        // R1: reset mid-frame returns to idle
        for (int i = 0; i < 3; i++) drive(pat(1, i), 1'b1, 1'b0);
        @(negedge clk); rst = 1'b1; dval = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        for (int i = 0; i < 8; i++) drive(pat(13, i), 1'b1, i == 7);
        tgt++; wait_frame(tgt, 1'b0);

        repeat (3) @(negedge clk);
        report();
        $finish;
    end

endmodule